// File: doc/BRIEF.md
# Machine-Cycle Timing Sequencer

This block derives all processor machine-cycle timing from one master oscillator. A prescaler turns the oscillator into a phase enable. In normal operation the prescaler divides by three (slow) or by two (fast, selected by `turbo`). In single-step mode each press of a debounced push-button produces exactly one enable and the oscillator is ignored. A sequencer advances one phase per enable. It produces an address strobe, a non-overlapping two-phase clock, a valid-memory-address flag and a one-clock end-of-cycle pulse.

Each machine cycle has one of two forms:
- **Idle cycle:** exactly three phases (strobe, phase-1, phase-2) with the valid-memory-address flag low.
- **Memory-reference cycle:** phase-1 is stretched by wait phases. The count of wait phases comes from the two top address bits, which are latched together with the request at the start of the cycle. An external ready line can stretch the cycle further.

The processor presents its request and upper address bits before a cycle starts. It uses `cycle_done` to know when the next cycle's inputs are taken.

Top module: `bus_cycle_timer`

## Requirements
- R1: With `turbo` low, every sequencer phase lasts exactly 3 oscillator clocks.
- R2: With `turbo` high, every phase lasts exactly 2 clocks. A change of `turbo` made in the first clock of a cycle applies to the whole of that cycle.
- R3: A cycle started with `mem_req` low is an idle cycle. It lasts 3 phases with `vma` low, and `ready` has no effect on it.
- R4: A cycle started with `mem_req` high lasts 3 + N phases with `vma` high. N depends on `addr_hi`: 2'b00 and 2'b01 (RAM) give N=1, 2'b10 (ROM) gives N=2, 2'b11 (I/O) gives N=4.
- R5: Phase order in every cycle is as follows. `addr_strobe` is high in the first phase only. `phi1` is high in the second phase and in every wait phase. `phi2` is high in the last phase only. No two of these three are high together.
- R6: `mem_req` and `addr_hi` are sampled only on the clock that ends a cycle. `vma` and the wait count are held for the whole following cycle, whatever the inputs do meanwhile.
- R7: In a memory cycle, once the decoded wait phases are used up, each phase enable seen with `ready` low adds another wait phase. The cycle ends only after an enable seen with `ready` high.
- R8: In step mode, each rising edge of `step_btn` (after a two-flop synchronizer) advances the sequencer by exactly one phase. No phase advances without a press.
- R9: While `rst` is high, the sequencer is held in phase 0 of an idle cycle with `addr_strobe`, `vma`, `phi1`, `phi2` and `cycle_done` all low. The first cycle after reset is idle and has no strobe.
- R10: `cycle_done` is high for exactly one clock, the last clock of every cycle. The next clock starts a new cycle with `addr_strobe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator |
| rst | input | 1 | Synchronous active-high reset |
| turbo | input | 1 | 1 = divide by 2, 0 = divide by 3 |
| step_mode | input | 1 | 1 = phases advance only on button presses |
| step_btn | input | 1 | Debounced single-step push-button, asynchronous |
| mem_req | input | 1 | Next cycle carries a memory reference |
| addr_hi | input | 2 | Two most significant address bits of the next cycle |
| ready | input | 1 | Low extends a memory cycle beyond its decoded waits |
| phi1 | output | 1 | Clock phase 1, stretched through wait phases |
| phi2 | output | 1 | Clock phase 2, last phase of a cycle |
| addr_strobe | output | 1 | First phase of every cycle after reset |
| vma | output | 1 | Valid memory address for the current cycle |
| cycle_done | output | 1 | One-clock pulse on the last clock of a cycle |

## Verification
The assertions check several properties on every clock:
- the three timing outputs never overlap;
- `cycle_done` never lasts two clocks and is always followed by a strobe;
- `vma` changes only right after `cycle_done`;
- an idle request clears `vma`;
- reset leaves all outputs quiet.

Other behaviour can only be shown by the bench's scenarios, because it needs a whole-cycle count: the exact phase and cycle lengths per address region and per prescale ratio, the extra waits driven by `ready`, and the one-phase-per-press behaviour of step mode.

// File: rtl/bct_pkg.sv
package bct_pkg;

    typedef enum logic [2:0] {
        PH_REST = 3'd0,
        PH_T0   = 3'd1,
        PH_T1   = 3'd2,
        PH_WAIT = 3'd3,
        PH_T2   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_ROM = 2'd1,
        RGN_IO  = 2'd2
    } region_e;

    // Top address bit clear selects RAM; otherwise the next bit picks ROM or I/O.
    function automatic region_e region_of(input logic [1:0] hi);
        if (!hi[1])
            return RGN_RAM;
        else if (!hi[0])
            return RGN_ROM;
        else
            return RGN_IO;
    endfunction

    function automatic int unsigned max_of3(input int unsigned a, input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bct_step_sync.sv
module bct_step_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic press
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[STAGES-1:0], btn};
    end

    // Rising edge of the synchronized button: one clock per press.
    assign press = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/bct_prescaler.sv
module bct_prescaler #(
    parameter int DIV_SLOW    = 3,
    parameter int DIV_FAST    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic turbo,
    input  logic step_mode,
    input  logic step_btn,
    output logic tick
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             wrap;
    logic             press;

    bct_step_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .btn  (step_btn),
        .press(press)
    );

    assign lim  = turbo ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);
    assign wrap = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || step_mode)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = step_mode ? press : wrap;
endmodule

// File: rtl/bct_region_decode.sv
module bct_region_decode
    import bct_pkg::*;
#(
    parameter int WCNT_W   = 3,
    parameter int WAIT_RAM = 1,
    parameter int WAIT_ROM = 2,
    parameter int WAIT_IO  = 4
) (
    input  logic              mem_req,
    input  logic [1:0]        addr_hi,
    output logic [WCNT_W-1:0] waits
);
    region_e rgn;

    assign rgn = region_of(addr_hi);

    always_comb begin
        if (!mem_req)
            waits = '0;
        else begin
            case (rgn)
                RGN_RAM: waits = WCNT_W'(WAIT_RAM);
                RGN_ROM: waits = WCNT_W'(WAIT_ROM);
                default: waits = WCNT_W'(WAIT_IO);
            endcase
        end
    end
endmodule

// File: rtl/bct_sequencer.sv
module bct_sequencer
    import bct_pkg::*;
#(
    parameter int WCNT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ready,
    input  logic              mem_in,
    input  logic [WCNT_W-1:0] waits_in,
    output logic              phi1,
    output logic              phi2,
    output logic              addr_strobe,
    output logic              vma,
    output logic              cycle_done
);
    phase_e            ph, ph_n;
    logic              mem_l;
    logic [WCNT_W-1:0] wcnt, wcnt_n;
    logic              start;

    always_comb begin
        ph_n   = ph;
        wcnt_n = wcnt;
        if (tick) begin
            case (ph)
                PH_REST, PH_T0: ph_n = PH_T1;
                PH_T1, PH_WAIT: begin
                    if (wcnt != '0) begin
                        ph_n   = PH_WAIT;
                        wcnt_n = wcnt - 1'b1;
                    end else if (mem_l && !ready)
                        ph_n = PH_WAIT;
                    else
                        ph_n = PH_T2;
                end
                PH_T2:   ph_n = PH_T0;
                default: ph_n = PH_REST;
            endcase
        end
    end

    assign start = tick && (ph == PH_T2);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_REST;
            mem_l <= 1'b0;
            wcnt  <= '0;
        end else begin
            ph <= ph_n;
            if (start) begin
                mem_l <= mem_in;
                wcnt  <= waits_in;
            end else
                wcnt <= wcnt_n;
        end
    end

    assign addr_strobe = (ph == PH_T0);
    assign phi1        = (ph == PH_T1) || (ph == PH_WAIT);
    assign phi2        = (ph == PH_T2);
    assign vma         = mem_l;
    assign cycle_done  = start;
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import bct_pkg::*;
#(
    parameter int DIV_SLOW    = 3,
    parameter int DIV_FAST    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_RAM    = 1,
    parameter int WAIT_ROM    = 2,
    parameter int WAIT_IO     = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       turbo,
    input  logic       step_mode,
    input  logic       step_btn,
    input  logic       mem_req,
    input  logic [1:0] addr_hi,
    input  logic       ready,
    output logic       phi1,
    output logic       phi2,
    output logic       addr_strobe,
    output logic       vma,
    output logic       cycle_done
);
    localparam int WAIT_MAX = int'(max_of3(WAIT_RAM, WAIT_ROM, WAIT_IO));
    localparam int WCNT_W   = $clog2(WAIT_MAX + 1);

    logic              tick;
    logic [WCNT_W-1:0] waits;

    bct_prescaler #(
        .DIV_SLOW   (DIV_SLOW),
        .DIV_FAST   (DIV_FAST),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .turbo    (turbo),
        .step_mode(step_mode),
        .step_btn (step_btn),
        .tick     (tick)
    );

    bct_region_decode #(
        .WCNT_W  (WCNT_W),
        .WAIT_RAM(WAIT_RAM),
        .WAIT_ROM(WAIT_ROM),
        .WAIT_IO (WAIT_IO)
    ) u_dec (
        .mem_req(mem_req),
        .addr_hi(addr_hi),
        .waits  (waits)
    );

    bct_sequencer #(.WCNT_W(WCNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .ready      (ready),
        .mem_in     (mem_req),
        .waits_in   (waits),
        .phi1       (phi1),
        .phi2       (phi2),
        .addr_strobe(addr_strobe),
        .vma        (vma),
        .cycle_done (cycle_done)
    );
endmodule

// File: rtl/bct_checker.sv
module bct_checker (
    input logic clk,
    input logic rst,
    input logic mem_req,
    input logic phi1,
    input logic phi2,
    input logic addr_strobe,
    input logic vma,
    input logic cycle_done
);
    p_phase_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(phi1 && phi2) && !(addr_strobe && (phi1 || phi2)));

    p_strobe_after_done_r5: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> addr_strobe);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> !cycle_done);

    p_vma_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cycle_done |=> $stable(vma));

    p_idle_drops_vma_r3: assert property (@(posedge clk) disable iff (rst)
        (cycle_done && !mem_req) |=> !vma);

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> !(addr_strobe || vma || phi1 || phi2 || cycle_done));
endmodule

bind bus_cycle_timer bct_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .phi1       (phi1),
    .phi2       (phi2),
    .addr_strobe(addr_strobe),
    .vma        (vma),
    .cycle_done (cycle_done)
);

// File: tb/bus_cycle_timer_bench.sv
module bus_cycle_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, turbo, step_mode, step_btn, mem_req, ready;
    logic [1:0] addr_hi;
    logic       phi1, phi2, addr_strobe, vma, cycle_done;

    int  total = 0;
    int  fails = 0;
    int  done_cnt = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_timer u_bus_cycle_timer (
        .clk(clk), .rst(rst), .turbo(turbo), .step_mode(step_mode),
        .step_btn(step_btn), .mem_req(mem_req), .addr_hi(addr_hi), .ready(ready),
        .phi1(phi1), .phi2(phi2), .addr_strobe(addr_strobe), .vma(vma),
        .cycle_done(cycle_done)
    );

    always @(negedge clk) if (!rst && cycle_done) done_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, addr_strobe, phi1, phi2, vma};
    endfunction

    function automatic int exp_waits(input logic [1:0] hi);
        if (hi[1] == 1'b0) return 1;
        if (hi[0] == 1'b0) return 2;
        return 4;
    endfunction

    function automatic int exp_phases(input bit mem, input logic [1:0] hi);
        return mem ? 3 + exp_waits(hi) : 3;
    endfunction

    task automatic press();
        step_btn = 1'b1;
        repeat (4) @(negedge clk);
        step_btn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        int  len, as_c, p1_c, p2_c, vbad, cycles, div, t;
        bit  first, tpend, chk_low, emem;
        logic [1:0] ehi;
        void'($urandom(32'd2718));

        rst = 1; turbo = 0; step_mode = 1; step_btn = 0;
        mem_req = 1; addr_hi = 2'b00; ready = 1;
        repeat (3) @(negedge clk);
        chk("R9 reset outputs", {outs(), 27'd0, cycle_done}, 0);

        // ---- single-step scenario (R8, R7, R6) ----
        rst = 0;
        repeat (20) @(negedge clk);
        chk("R8 no advance without press", outs(), 0);
        press();
        chk("R9 first cycle idle phase1", outs(), 4'b0100);
        press();
        chk("R8 step to phase2", outs(), 4'b0010);
        press();
        chk("R5 strobe with RAM vma", outs(), 4'b1001);
        chk("R10 done count after idle", done_cnt, 1);
        ready = 0; mem_req = 0; addr_hi = 2'b11;
        press();
        chk("R6 vma held despite inputs", outs(), 4'b0101);
        press();
        chk("R4 RAM decoded wait", outs(), 4'b0101);
        press();
        chk("R7 ready low extra wait", outs(), 4'b0101);
        repeat (15) @(negedge clk);
        chk("R8 held between presses", outs(), 4'b0101);
        press();
        chk("R7 second extra wait", outs(), 4'b0101);
        chk("R7 no done while not ready", done_cnt, 1);
        ready = 1;
        press();
        chk("R7 ready releases to phase2", outs(), 4'b0011);
        press();
        chk("R3 idle request clears vma", outs(), 4'b1000);
        chk("R10 done count after memory", done_cnt, 2);
        // ready low during an idle cycle has no effect
        ready = 0;
        press(); press();
        chk("R3 idle ignores ready", outs(), 4'b0010);
        ready = 1;

        // ---- free-running random scenario (R1..R6, R10) ----
        rst = 1; step_mode = 0; turbo = 0; mem_req = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        len = 0; as_c = 0; p1_c = 0; p2_c = 0; vbad = 0; cycles = 0;
        div = 3; first = 1; tpend = 0; chk_low = 0; emem = 0; ehi = 2'b00;
        while (cycles < 300) begin
            @(negedge clk);
            if (chk_low) begin
                chk("R10 done lasts one clock", int'(cycle_done), 0);
                chk_low = 0;
            end
            len++;
            if (len == 1 && tpend) begin
                turbo = ~turbo;
                div = turbo ? 2 : 3;
                tpend = 0;
            end
            as_c += int'(addr_strobe);
            p1_c += int'(phi1);
            p2_c += int'(phi2);
            if (vma !== emem) vbad++;
            if (cycle_done) begin
                if (!first) begin
                    t = exp_phases(emem, ehi);
                    chk(emem ? "R4 memory cycle length" : "R3 idle cycle length",
                        len, t * div);
                    chk(turbo ? "R2 phase length fast" : "R1 phase length slow",
                        as_c, div);
                    chk("R5 phi1 span", p1_c, div * (t - 2));
                    chk("R5 phi2 span", p2_c, div);
                    chk("R6 vma stable in cycle", vbad, 0);
                    cycles++;
                end
                first = 0;
                emem = (($urandom % 4) != 0);
                ehi = 2'($urandom);
                mem_req = emem;
                addr_hi = ehi;
                tpend = (($urandom % 6) == 0);
                chk_low = 1;
                len = 0; as_c = 0; p1_c = 0; p2_c = 0; vbad = 0;
            end else begin
                if ($urandom % 2) mem_req = 1'($urandom);
                if ($urandom % 2) addr_hi = 2'($urandom);
            end
        end

        // ---- reset in the middle of activity (R9) ----
        rst = 1;
        @(negedge clk);
        chk("R9 mid-run reset outputs", {outs(), 27'd0, cycle_done}, 0);
        report();
    end
endmodule